// File: doc/BRIEF.md
# Infrared pulse-timing capture receiver

This block measures the timing of a demodulated remote-control signal. The input is sampled on a tick that comes from the system clock divided by a programmable integer. The sample rate is normally set to 10 MHz, so one tick is 100 ns. For each symbol the block records two 16-bit tick counts:

- how long the carrier was present (the mark);
- the whole period from the start of that mark to the start of the next one.

Software gets the space length by subtracting the mark from the period. Each pair goes into an eight-entry FIFO. If the line stays idle longer than a programmable maximum period, the train is closed with a pair whose period field reads 0xFFFF.

Software drives the block through a simple memory-mapped register port. The port sets the divisor, input polarity, receive enable, the idle limit and the interrupt enables. It also reads the captured pairs, which pops the FIFO, and reads the status, occupancy and overflow information. A single level interrupt reports symbols, train ends, a full FIFO and overruns.

Top module: `ir_pulse_capture`

## Requirements
- R1: One sample is taken every D clocks while enabled, where D is the divisor at offset 0x60 (reset 1; 0 acts as 1).
- R2: A mark is a high sample, or a low sample when bit 0 of offset 0x68 is set. At the next mark start the pair {mark ticks, ticks from mark start to next mark start} is pushed.
- R3: During a space, a low sample with the period count at or above the limit at offset 0x54 (reset 0x5000) pushes {mark, 0xFFFF} and ends the train.
- R4: The mark and period counters are 16 bits wide and stop at 0xFFFF instead of wrapping.
- R5: The FIFO holds 8 pairs. Reading offset 0x44 returns the head period and pops it. Reading offset 0x40 returns the head mark without popping. Both read 0 when the FIFO is empty.
- R6: A push into a full FIFO is dropped, leaves the stored pairs unchanged, and sets overrun status bit 2.
- R7: Status at 0x4C: bit 0 is set by a stored pair, bit 1 by a stored timeout pair, bit 2 by an overrun, and bit 3 when a push fills the FIFO. Writing 1s to 0x58 clears the matching bits, and a same-cycle set wins.
- R8: irq is high exactly when some status bit is set and its enable bit at 0x48 is also set. Both registers reset to 0.
- R9: Offset 0x6C returns the FIFO occupancy in bits 15:8 and the overrun flag in bit 2.
- R10: While bit 0 of offset 0x50 is clear, the counters and FIFO are held empty and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_in | input | 1 | Demodulated receiver level, already synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the period offset) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take three things for granted:
- ir_in is already synchronous to clk;
- the FIFO depth is a power of two;
- each bus access is one strobe held across a single clock edge.

The stimulus keeps to all three: it changes ir_in and the bus signals one time unit after a rising edge, and it issues each read or write for exactly one edge. The idle limit and divisor are reprogrammed only while the line is in a known state. Input polarity is changed only with capture disabled, so no half-counted symbol mixes the two senses.

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture #(
  parameter int DEPTH = 8,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [CW-1:0] MAXP_RST = 16'h5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ir_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] SAT = '1;
  localparam logic [AW-1:0] A_MARK = AW'(8'h40);
  localparam logic [AW-1:0] A_PER  = AW'(8'h44);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h48);
  localparam logic [AW-1:0] A_IST  = AW'(8'h4C);
  localparam logic [AW-1:0] A_EN   = AW'(8'h50);
  localparam logic [AW-1:0] A_MAXP = AW'(8'h54);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h58);
  localparam logic [AW-1:0] A_DIV  = AW'(8'h60);
  localparam logic [AW-1:0] A_INV  = AW'(8'h68);
  localparam logic [AW-1:0] A_RXS  = AW'(8'h6C);

  typedef enum logic [1:0] {IDLE, MARK, SPACE} cap_t;

  logic [DW-1:0] div_q, dcnt_q, dlim;
  logic          inv_q, en_q;
  logic [CW-1:0] maxp_q, mark_q, sym_q;
  logic [3:0]    ien_q, ist_q, clr, set;
  cap_t          st_q;
  logic [CW-1:0] mmem [DEPTH];
  logic [CW-1:0] smem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;
  logic tick, s, push, tmo, acc, pop, full, empty;
  logic unused_ok;

  function automatic logic [CW-1:0] sinc(input logic [CW-1:0] v);
    return (v == SAT) ? v : v + 1'b1;
  endfunction

  assign unused_ok = ^bus_wdata[31:CW];
  assign dlim  = (div_q == '0) ? '0 : div_q - 1'b1;
  assign tick  = en_q && (dcnt_q >= dlim);
  assign s     = ir_in ^ inv_q;
  assign full  = cnt_q == (PW+1)'(DEPTH);
  assign empty = cnt_q == '0;
  assign pop   = bus_rd && bus_addr == A_PER && !empty;
  assign push  = tick && st_q == SPACE && (s || sym_q >= maxp_q);
  assign tmo   = tick && st_q == SPACE && !s && sym_q >= maxp_q;
  assign acc   = push && !full;
  assign clr   = (bus_wr && bus_addr == A_CLR) ? bus_wdata[3:0] : 4'b0;
  assign set   = {acc && !pop && cnt_q == (PW+1)'(DEPTH-1), push && full, acc && tmo, acc};
  assign irq   = |(ist_q & ien_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= DW'(1); inv_q <= 1'b0; en_q <= 1'b0;
      maxp_q <= MAXP_RST; ien_q <= '0; ist_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_DIV)  div_q  <= bus_wdata[DW-1:0];
      if (bus_wr && bus_addr == A_INV)  inv_q  <= bus_wdata[0];
      if (bus_wr && bus_addr == A_EN)   en_q   <= bus_wdata[0];
      if (bus_wr && bus_addr == A_MAXP) maxp_q <= bus_wdata[CW-1:0];
      if (bus_wr && bus_addr == A_IEN)  ien_q  <= bus_wdata[3:0];
      ist_q <= (ist_q & ~clr) | set;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dcnt_q <= '0; st_q <= IDLE; mark_q <= '0; sym_q <= '0;
    end else if (!en_q) begin
      dcnt_q <= '0; st_q <= IDLE; mark_q <= '0; sym_q <= '0;
    end else begin
      dcnt_q <= tick ? '0 : dcnt_q + 1'b1;
      if (tick)
        case (st_q)
          IDLE:  if (s) begin st_q <= MARK; mark_q <= CW'(1); sym_q <= CW'(1); end
          MARK: begin
            sym_q <= sinc(sym_q);
            if (s) mark_q <= sinc(mark_q);
            else   st_q <= SPACE;
          end
          default:
            if (s) begin st_q <= MARK; mark_q <= CW'(1); sym_q <= CW'(1); end
            else if (tmo) st_q <= IDLE;
            else sym_q <= sinc(sym_q);
        endcase
    end

  always_ff @(posedge clk)
    if (acc) begin
      mmem[wp_q] <= mark_q;
      smem[wp_q] <= tmo ? SAT : sym_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (!en_q) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (acc) wp_q <= wp_q + 1'b1;
      if (pop) rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(acc) - (PW+1)'(pop);
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MARK: bus_rdata = empty ? '0 : 32'(mmem[rp_q]);
      A_PER:  bus_rdata = empty ? '0 : 32'(smem[rp_q]);
      A_IEN:  bus_rdata = 32'(ien_q);
      A_IST:  bus_rdata = 32'(ist_q);
      A_EN:   bus_rdata = 32'(en_q);
      A_MAXP: bus_rdata = 32'(maxp_q);
      A_DIV:  bus_rdata = 32'(div_q);
      A_INV:  bus_rdata = 32'(inv_q);
      A_RXS:  bus_rdata = {16'b0, 8'(cnt_q), 5'b0, ist_q[2], 2'b0};
      default: bus_rdata = '0;
    endcase
  end

  p_fifo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (PW+1)'(DEPTH));
  p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && pop && !acc) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_drop_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && push && full && !pop) |=> (cnt_q == $past(cnt_q)) && ist_q[2]);
  p_mark_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && st_q == MARK && mark_q == SAT) |=> mark_q == SAT);
  p_tmo_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && st_q == SPACE && !s && sym_q >= maxp_q) |=> st_q == IDLE);
  p_off_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (cnt_q == '0) && (st_q == IDLE));
endmodule

// File: tb/ir_pulse_capture_tb.sv
module ir_pulse_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_in = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ir_pulse_capture dut_i (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference
  int m_div, m_maxp, m_ien, m_ist, m_dcnt, m_st, m_mark, m_sym, m_set, m_clr, m_n0;
  bit m_en, m_inv, m_tick, m_s, m_full, m_pop, m_push, m_tmo, m_acc;
  int qm[$];
  int qs[$];

  function automatic int sat(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_div = 1; m_maxp = 'h5000; m_ien = 0; m_ist = 0; m_en = 0; m_inv = 0;
      m_dcnt = 0; m_st = 0; m_mark = 0; m_sym = 0; qm.delete(); qs.delete();
    end else begin
      m_tick = m_en && (m_dcnt >= ((m_div == 0) ? 0 : m_div - 1));
      m_s = ir_in ^ m_inv;
      m_n0 = qm.size();
      m_full = (m_n0 == 8);
      m_pop = bus_rd && bus_addr == 8'h44 && m_n0 > 0;
      m_push = 0; m_tmo = 0;
      if (m_tick && m_st == 2) begin
        if (m_s) m_push = 1;
        else if (m_sym >= m_maxp) begin m_push = 1; m_tmo = 1; end
      end
      m_acc = m_push && !m_full;
      m_set = 0;
      if (m_acc) m_set |= 1;
      if (m_acc && m_tmo) m_set |= 2;
      if (m_push && m_full) m_set |= 4;
      if (m_acc && !m_pop && m_n0 == 7) m_set |= 8;
      if (!m_en) begin qm.delete(); qs.delete(); end
      else begin
        if (m_pop) begin void'(qm.pop_front()); void'(qs.pop_front()); end
        if (m_acc) begin qm.push_back(m_mark); qs.push_back(m_tmo ? 65535 : m_sym); end
      end
      if (!m_en) begin m_st = 0; m_mark = 0; m_sym = 0; m_dcnt = 0; end
      else begin
        m_dcnt = m_tick ? 0 : m_dcnt + 1;
        if (m_tick) begin
          if (m_st == 0) begin
            if (m_s) begin m_st = 1; m_mark = 1; m_sym = 1; end
          end else if (m_st == 1) begin
            m_sym = sat(m_sym + 1);
            if (m_s) m_mark = sat(m_mark + 1); else m_st = 2;
          end else begin
            if (m_s) begin m_st = 1; m_mark = 1; m_sym = 1; end
            else if (m_tmo) m_st = 0;
            else m_sym = sat(m_sym + 1);
          end
        end
      end
      m_clr = (bus_wr && bus_addr == 8'h58) ? int'(bus_wdata[3:0]) : 0;
      if (bus_wr) begin
        if (bus_addr == 8'h60) m_div = int'(bus_wdata[7:0]);
        if (bus_addr == 8'h68) m_inv = bus_wdata[0];
        if (bus_addr == 8'h50) m_en = bus_wdata[0];
        if (bus_addr == 8'h54) m_maxp = int'(bus_wdata[15:0]);
        if (bus_addr == 8'h48) m_ien = int'(bus_wdata[3:0]);
      end
      m_ist = (m_ist & ~m_clr) | m_set;
    end

  function automatic logic [31:0] m_rd(input logic [7:0] a);
    case (a)
      8'h40: return (qm.size() == 0) ? 0 : qm[0];
      8'h44: return (qs.size() == 0) ? 0 : qs[0];
      8'h48: return m_ien;
      8'h4C: return m_ist;
      8'h50: return 32'(m_en);
      8'h54: return m_maxp;
      8'h60: return m_div;
      8'h68: return 32'(m_inv);
      8'h6C: return (qm.size() << 8) | (m_ist & 4);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h40, 8'h44: return "R5";
      8'h4C: return "R7";
      8'h6C: return "R9";
      8'h54: return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !done) begin
      chk(bus_rdata == m_rd(bus_addr), tag_of(bus_addr), bus_rdata, m_rd(bus_addr));
      chk(irq == ((m_ist & m_ien) != 0), "R8", 32'(irq), 32'((m_ist & m_ien) != 0));
    end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1 bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0; bus_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #1 bus_rd = 1; bus_addr = a;
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #1 bus_rd = 0; bus_addr = 8'h00;
  endtask

  task automatic lvl(input bit b, input int n);
    @(posedge clk); #1 ir_in = b;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    // reset state
    expect_rd(8'h54, 32'h5000, "R3");
    expect_rd(8'h60, 32'h1, "R1");
    expect_rd(8'h4C, 32'h0, "R7");
    chk(irq == 1'b0, "R8", 32'(irq), 0);
    wr(8'h48, 32'hF);
    wr(8'h50, 32'h1);
    // basic pair: mark 3, period 8
    lvl(1, 3); lvl(0, 5); lvl(1, 1);
    expect_rd(8'h40, 32'd3, "R2");
    expect_rd(8'h44, 32'd8, "R2");
    expect_rd(8'h6C, 32'h0, "R9");
    expect_rd(8'h4C, 32'h1, "R7");
    chk(irq == 1'b1, "R8", 32'(irq), 1);
    wr(8'h58, 32'hF);
    expect_rd(8'h4C, 32'h0, "R7");
    chk(irq == 1'b0, "R8", 32'(irq), 0);
    // timeout code
    wr(8'h54, 32'd20);
    wr(8'h50, 32'h0); lvl(0, 1); wr(8'h50, 32'h1);
    lvl(1, 3); lvl(0, 40);
    expect_rd(8'h40, 32'd3, "R3");
    expect_rd(8'h44, 32'hFFFF, "R3");
    expect_rd(8'h4C, 32'h3, "R7");
    wr(8'h58, 32'hF);
    // overflow
    for (int i = 0; i < 11; i++) begin lvl(1, 1); lvl(0, 1); end
    lvl(0, 30);
    expect_rd(8'h6C, 32'h0804, "R9");
    expect_rd(8'h4C, 32'hD, "R7");
    expect_rd(8'h40, 32'd1, "R6");
    expect_rd(8'h44, 32'd2, "R6");
    wr(8'h58, 32'h4);
    expect_rd(8'h4C, 32'h9, "R7");
    // disabled: nothing captured
    wr(8'h50, 32'h0);
    expect_rd(8'h6C, 32'h0, "R10");
    lvl(1, 3); lvl(0, 3); lvl(1, 3); lvl(0, 3);
    expect_rd(8'h6C, 32'h0, "R10");
    expect_rd(8'h40, 32'h0, "R10");
    // inverted polarity: low is mark
    wr(8'h68, 32'h1); lvl(1, 1); wr(8'h50, 32'h1);
    lvl(0, 4); lvl(1, 2); lvl(0, 1);
    expect_rd(8'h40, 32'd4, "R2");
    expect_rd(8'h44, 32'd6, "R2");
    wr(8'h50, 32'h0); wr(8'h68, 32'h0); lvl(0, 1);
    // divisor of 3
    wr(8'h54, 32'hFFFF); wr(8'h60, 32'd3); wr(8'h50, 32'h1);
    lvl(1, 30); lvl(0, 30); lvl(1, 3);
    rd(8'h40, v); chk(v >= 9 && v <= 11, "R1", v, 32'd10);
    rd(8'h44, v); chk(v >= 19 && v <= 21, "R1", v, 32'd20);
    // saturation
    wr(8'h50, 32'h0); wr(8'h60, 32'd1); lvl(0, 1); wr(8'h50, 32'h1);
    lvl(1, 70000); lvl(0, 3);
    expect_rd(8'h40, 32'hFFFF, "R4");
    expect_rd(8'h44, 32'hFFFF, "R4");
    finish_run();
  end
endmodule